// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatch Register

This block is a write-only command register that software uses to control other CPUs in a multi-processor chip. Each write carries three fields: a two-bit action code, a target CPU number and a six-bit vector. The block decodes every write and checks the CPU number against the configured CPU count. A valid write produces a single-cycle command pulse toward the selected CPU. The pulse carries the CPU index, the action code and the vector.

The four actions are as follows. Post delivers the vector as an interrupt. Reset restarts the CPU and leaves it running. Idle halts the CPU so that interrupts no longer wake it. Resume sets the CPU running again. A reset is accepted only when its vector equals the configured power-on-reset trap code. If the code does not match, the write is dropped and a sticky error flag is raised.

The block keeps one running bit per CPU. Downstream logic uses these bits to gate instruction fetch and interrupt wakeup. The CPU reset sequence itself, and the queuing of interrupts inside each CPU, belong to the receiving CPU.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset `cmdValid` is 0, every bit of `runMask` is 1 and `resetCodeErr` is 0.
- R2: The write data fields are fixed. The action code is in bits 17:16, with 0 = post, 1 = reset, 2 = idle and 3 = resume. The target CPU is in bits 12:8 and the vector is in bits 5:0. All other bits have no effect.
- R3: An accepted write raises `cmdValid` for exactly the cycle after the write edge, with `cmdCpu`, `cmdType` and `cmdVec` equal to the decoded fields. When no write is accepted at an edge, `cmdValid` is 0 in the following cycle.
- R4: A post (code 0) to an in-range CPU emits a command and does not change `runMask`.
- R5: A reset (code 1) whose vector equals `POR_VEC` emits a command and sets the target's running bit.
- R6: A reset whose vector differs from `POR_VEC` emits no command and leaves `runMask` unchanged. It sets `resetCodeErr`, which then stays 1 until reset.
- R7: An idle (code 2) emits a command and clears the target's running bit.
- R8: A resume (code 3) emits a command and sets the target's running bit.
- R9: A write whose target CPU is at or above `NUM_CPUS` is ignored: no command, no `runMask` change and no error, even if it carries a bad reset vector.
- R10: A post to an idle CPU emits its command but leaves that CPU's running bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the command register |
| wrData | input | DATA_W | Write data holding the action, CPU and vector fields |
| cmdValid | output | 1 | One-cycle command pulse |
| cmdCpu | output | 5 | Target CPU of the command |
| cmdType | output | 2 | Action code of the command |
| cmdVec | output | 6 | Vector of the command |
| runMask | output | NUM_CPUS | Running bit per CPU |
| resetCodeErr | output | 1 | Sticky flag for a reset with the wrong vector |

## Verification
The bench targets the following corner cases:

- **Out-of-range CPU numbers.** It writes CPU numbers just at `NUM_CPUS` and at the field maximum. A design with an off-by-one range check would pulse a command to a CPU that does not exist.
- **Bad reset vectors.** It sends resets with a wrong vector, both to valid and to out-of-range CPUs. A design that drops the vector check would wake the CPU. A design that checks the vector before the range would set the error flag on a write that should be ignored.
- **Post to an idle CPU.** It posts interrupts to idled CPUs. A design that treats a post as a wakeup would set the running bit again.
- **Junk in unused bits.** It fills the unused data bits with random junk. A design with a misplaced field slice would decode the wrong CPU or vector.
- **Pulse width.** It checks that the command pulse drops after one cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int TYPE_LO = 16;
  localparam int TYPE_W  = 2;
  localparam int CPU_LO  = 8;
  localparam int CPU_W   = 5;
  localparam int VEC_LO  = 0;
  localparam int VEC_W   = 6;

  typedef enum logic [TYPE_W-1:0] {
    CMD_POST   = 2'd0,
    CMD_RESET  = 2'd1,
    CMD_IDLE   = 2'd2,
    CMD_RESUME = 2'd3
  } ipi_cmd_e;

  typedef struct packed {
    logic fire;
    logic setRun;
    logic clrRun;
    logic setErr;
  } ipi_strb_t;

endpackage

// File: rtl/ipi_decode_ctrl.sv
module ipi_decode_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  ipi_cmd_e         wrType,
  input  logic [CPU_W-1:0] wrCpu,
  input  logic [VEC_W-1:0] wrVec,
  output ipi_strb_t        strb
);

  localparam logic [CPU_W:0] CPU_LIMIT = (CPU_W+1)'(NUM_CPUS);

  logic inRange;
  logic porOk;
  logic accept;

  assign inRange = {1'b0, wrCpu} < CPU_LIMIT;
  assign porOk   = (wrVec == POR_VEC);
  assign accept  = wrEn && inRange;

  always_comb begin
    strb = '0;
    if (accept) begin
      unique case (wrType)
        CMD_POST: strb.fire = 1'b1;
        CMD_RESET: begin
          if (porOk) begin
            strb.fire   = 1'b1;
            strb.setRun = 1'b1;
          end else begin
            strb.setErr = 1'b1;
          end
        end
        CMD_IDLE: begin
          strb.fire   = 1'b1;
          strb.clrRun = 1'b1;
        end
        CMD_RESUME: begin
          strb.fire   = 1'b1;
          strb.setRun = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

  // R6: a rejected reset never produces a command
  assert_bad_reset_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |-> !strb.fire);

  // R9: nothing is strobed for a CPU outside the configured range
  assert_range_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inRange) |-> (strb == '0));

endmodule

// File: rtl/ipi_cmd_datapath.sv
module ipi_cmd_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  ipi_strb_t           strb,
  input  ipi_cmd_e            wrType,
  input  logic [CPU_W-1:0]    wrCpu,
  input  logic [VEC_W-1:0]    wrVec,
  output logic                cmdValid,
  output logic [CPU_W-1:0]    cmdCpu,
  output ipi_cmd_e            cmdType,
  output logic [VEC_W-1:0]    cmdVec,
  output logic [NUM_CPUS-1:0] runMask,
  output logic                resetCodeErr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCpu   <= '0;
      cmdType  <= CMD_POST;
      cmdVec   <= '0;
    end else begin
      cmdValid <= strb.fire;
      if (strb.fire) begin
        cmdCpu  <= wrCpu;
        cmdType <= wrType;
        cmdVec  <= wrVec;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetCodeErr <= 1'b0;
    else if (strb.setErr) resetCodeErr <= 1'b1;
  end

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_run
    logic hit;
    assign hit = strb.fire && (wrCpu == CPU_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) runMask[i] <= 1'b1;
      else if (hit && strb.setRun) runMask[i] <= 1'b1;
      else if (hit && strb.clrRun) runMask[i] <= 1'b0;
    end
  end

  // R7: an issued idle command leaves its CPU halted
  assert_idle_halts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == CMD_IDLE) |-> !(1'(runMask >> cmdCpu)));

  // R5 / R8: issued reset or resume leaves its CPU running
  assert_wake_runs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdType == CMD_RESET || cmdType == CMD_RESUME)) |-> 1'(runMask >> cmdCpu));

  // R5: an issued reset always carries the power-on code
  assert_reset_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == CMD_RESET) |-> (cmdVec == POR_VEC));

  // R6: error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetCodeErr |=> resetCodeErr);

  // R9: every command targets an existing CPU
  assert_cmd_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ({1'b0, cmdCpu} < (CPU_W+1)'(NUM_CPUS)));

  // R4 / R10: a post never alters the running bits
  assert_post_keeps_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && wrType == CMD_POST) |=> $stable(runMask));

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic                cmdValid,
  output logic [4:0]          cmdCpu,
  output logic [1:0]          cmdType,
  output logic [5:0]          cmdVec,
  output logic [NUM_CPUS-1:0] runMask,
  output logic                resetCodeErr
);

  ipi_cmd_e         wrType;
  logic [CPU_W-1:0] wrCpu;
  logic [VEC_W-1:0] wrVec;
  ipi_strb_t        strb;
  ipi_cmd_e         cmdTypeE;
  logic             unusedBits;

  assign wrType = ipi_cmd_e'(wrData[TYPE_LO +: TYPE_W]);
  assign wrCpu  = wrData[CPU_LO +: CPU_W];
  assign wrVec  = wrData[VEC_LO +: VEC_W];
  assign unusedBits = ^{wrData[DATA_W-1:TYPE_LO+TYPE_W],
                        wrData[TYPE_LO-1:CPU_LO+CPU_W],
                        wrData[CPU_LO-1:VEC_LO+VEC_W]};

  ipi_decode_ctrl #(.NUM_CPUS(NUM_CPUS), .POR_VEC(POR_VEC)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrType(wrType), .wrCpu(wrCpu), .wrVec(wrVec), .strb(strb)
  );

  ipi_cmd_datapath #(.NUM_CPUS(NUM_CPUS), .POR_VEC(POR_VEC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrType(wrType), .wrCpu(wrCpu), .wrVec(wrVec),
    .cmdValid(cmdValid), .cmdCpu(cmdCpu), .cmdType(cmdTypeE), .cmdVec(cmdVec),
    .runMask(runMask), .resetCodeErr(resetCodeErr)
  );

  assign cmdType = cmdTypeE;

  // R3: the command pulse lasts one cycle unless another write is accepted
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !strb.fire) |=> !cmdValid);

endmodule

// File: tb/ipi_dispatch_tb_top.sv
`timescale 1ns/1ps
module ipi_dispatch_tb_top;

  localparam int NCPU = 8;
  localparam logic [5:0] POR = 6'h01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        cmdValid;
  logic [4:0]  cmdCpu;
  logic [1:0]  cmdType;
  logic [5:0]  cmdVec;
  logic [NCPU-1:0] runMask;
  logic        resetCodeErr;

  int checks = 0;
  int fails  = 0;
  logic [NCPU-1:0] expRun = '1;
  logic            expErr = 1'b0;

  always #2 clk = ~clk;

  ipi_dispatch #(.DATA_W(64), .NUM_CPUS(NCPU), .POR_VEC(POR)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cmdValid(cmdValid), .cmdCpu(cmdCpu), .cmdType(cmdType), .cmdVec(cmdVec),
    .runMask(runMask), .resetCodeErr(resetCodeErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic accepted(input logic [1:0] t, input logic [4:0] c, input logic [5:0] v);
    return (int'(c) < NCPU) && !(t == 2'd1 && v != POR);
  endfunction

  task automatic doWrite(input string req, input logic [1:0] t, input logic [4:0] c, input logic [5:0] v);
    logic [63:0] d;
    logic fire;
    d = {$urandom, $urandom};
    d[17:16] = t; d[12:8] = c; d[5:0] = v;
    fire = accepted(t, c, v);
    if (int'(c) < NCPU) begin
      if (t == 2'd1 && v != POR) expErr = 1'b1;
      if (fire && (t == 2'd1 || t == 2'd3)) expRun[c[2:0]] = 1'b1;
      if (fire && t == 2'd2) expRun[c[2:0]] = 1'b0;
    end
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = {$urandom, $urandom};
    chk({req, " valid"}, 64'(cmdValid), 64'(fire));
    if (fire) begin
      chk({req, " R2 R3 fields"}, {cmdType, cmdCpu, cmdVec}, {t, c, v});
    end
    chk({req, " runMask"}, 64'(runMask), 64'(expRun));
    chk({req, " R6 err"}, 64'(resetCodeErr), 64'(expErr));
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk("R3 pulse dropped", 64'(cmdValid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cmdValid", 64'(cmdValid), 64'd0);
    chk("R1 runMask", 64'(runMask), 64'(expRun));
    chk("R1 err", 64'(resetCodeErr), 64'd0);

    doWrite("R9 bad reset out of range", 2'd1, 5'd8, 6'h3f);
    doWrite("R9 cpu at limit", 2'd0, 5'd8, 6'h12);
    doWrite("R9 cpu max field", 2'd2, 5'd31, 6'h05);
    doWrite("R4 post", 2'd0, 5'd3, 6'h2a);
    idleCheck();
    doWrite("R7 idle", 2'd2, 5'd3, 6'h00);
    doWrite("R10 post to idle", 2'd0, 5'd3, 6'h11);
    doWrite("R8 resume", 2'd3, 5'd3, 6'h07);
    doWrite("R7 idle top cpu", 2'd2, 5'd7, 6'h00);
    doWrite("R5 reset good", 2'd1, 5'd7, POR);
    doWrite("R6 reset bad", 2'd1, 5'd0, 6'h02);
    doWrite("R6 sticky after post", 2'd0, 5'd0, 6'h01);
    idleCheck();

    for (int n = 0; n < 400; n++) begin
      logic [1:0] t;
      logic [4:0] c;
      logic [5:0] v;
      t = 2'($urandom);
      c = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % NCPU);
      v = (t == 2'd1 && ($urandom % 2 == 0)) ? POR : 6'($urandom);
      doWrite("R3 random", t, c, v);
      if ($urandom % 5 == 0) idleCheck();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule